// File: doc/BRIEF.md
# Width-Converting Dual-Port RAM with Byte Parity

This block is a synchronous true dual-port memory with two independent ports, A and B. Each port has its own clock, enable, write enable, synchronous output set/reset, address, write data, write parity, read data and read parity. Both ports address the same 16 kbit of data storage and 2 kbit of parity storage. Each port is built for its own word shape through a parameter, so one side can write narrow words while the other reads wide ones. Writing bytes on one port and reading single bits on the other turns parallel words into a serial stream.

Parity is held apart from the data. A port sees it only when its shape is byte-based (8+1, 16+2 or 32+4). Each port registers its read result in an output register. That register powers up to a per-port parameter value and loads a second per-port value on a synchronous set/reset. The data storage can be preloaded from a seed parameter.

Top module: `dpram_wconv`

## Requirements
- R1: The shape codes are SHAPE_X1=0, X2=1, X4=2, X9=3, X18=4 and X36=5. They give data widths of 1, 2, 4, 8, 16 and 32 bits and depths of 16384, 8192, 4096, 2048, 1024 and 512 words. A port of data width W and address a holds data bits a*W to a*W+W-1 of the shared 16384-bit data space. Only the low log2(depth) address bits are used, and higher address bits are ignored.
- R2: Data written through one port is read through the other port using the same shared bit numbering, whatever the two widths. Writing 8-bit words on A and reading 1-bit words on B returns the bits of each byte, least significant first.
- R3: Parity is one bit per data byte. A port of parity width P=W/8 (W at least 8) and address a holds parity bits a*P to a*P+P-1 of a separate 2048-bit parity space. A port with a 1-, 2- or 4-bit shape returns parity 0 and never changes parity storage.
- R4: With en high and sr low, the output register loads the addressed word one clock edge after the request. When we is also high, it returns the contents from before the write (read-before-write).
- R5: With en and sr high, the output register loads the port's SRVAL parameter, masked to the port's data and parity widths. A write requested in the same cycle still takes place.
- R6: With en low, the output register keeps its value and no write takes place, whatever we, sr, address and data are.
- R7: At power-up, each output register holds the port's INIT_OUT parameter, masked to the port's widths. Each 32-bit storage row r holds h = (r*32'h9E3779B1) XOR PRELOAD_SEED as data bits 32r to 32r+31. Its parity bits 4r to 4r+3 hold h[7:4] XOR h[31:28].
- R8: The port value is laid out as {parity[3:0], data[31:0]}, both LSB-aligned. Output bits above the port's data width, and above its parity width, always read 0. Input bits above those widths are ignored.
- R9: The ports run on unrelated clocks, and operations on disjoint bits proceed concurrently without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| sr_a | input | 1 | Port A synchronous output set/reset |
| addr_a | input | 14 | Port A word address |
| din_a | input | 32 | Port A write data |
| pin_a | input | 4 | Port A write parity |
| dout_a | output | 32 | Port A registered read data |
| pout_a | output | 4 | Port A registered read parity |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| sr_b | input | 1 | Port B synchronous output set/reset |
| addr_b | input | 14 | Port B word address |
| din_b | input | 32 | Port B write data |
| pin_b | input | 4 | Port B write parity |
| dout_b | output | 32 | Port B registered read data |
| pout_b | output | 4 | Port B registered read parity |

## Verification
On one port, a write and an output set/reset can fall on the same edge. A write and a read of the same word also fall on the same edge whenever we is high. The bench requests set/reset together with a write: it expects SRVAL on the output and then reads the word back, expecting the new data. For the write-and-read case it expects the old contents on that same edge. Concurrent activity on both clocks is provoked with overlapping write and read bursts on disjoint bits, and every output is judged against the reference model on every clock of its port.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int ADDR_W   = 14;
    localparam int ROW_DATA = 32;
    localparam int ROW_PAR  = 4;
    localparam int ROW_W    = ROW_DATA + ROW_PAR;
    localparam int ROW_AW   = 9;
    localparam int ROWS     = 1 << ROW_AW;

    typedef enum logic [2:0] {
        SHAPE_X1  = 3'd0,
        SHAPE_X2  = 3'd1,
        SHAPE_X4  = 3'd2,
        SHAPE_X9  = 3'd3,
        SHAPE_X18 = 3'd4,
        SHAPE_X36 = 3'd5
    } shape_e;

    function automatic int shape_dw(shape_e s);
        case (s)
            SHAPE_X1:  return 1;
            SHAPE_X2:  return 2;
            SHAPE_X4:  return 4;
            SHAPE_X9:  return 8;
            SHAPE_X18: return 16;
            default:   return 32;
        endcase
    endfunction

    function automatic int shape_pw(shape_e s);
        return (shape_dw(s) >= 8) ? shape_dw(s) / 8 : 0;
    endfunction

    function automatic logic [ROW_DATA-1:0] data_keep(shape_e s);
        return (shape_dw(s) == ROW_DATA) ? '1 : ROW_DATA'((64'd1 << shape_dw(s)) - 64'd1);
    endfunction

    function automatic logic [ROW_PAR-1:0] par_keep(shape_e s);
        return ROW_PAR'((32'd1 << shape_pw(s)) - 32'd1);
    endfunction

    // Power-up content of one storage row: {parity nibble, data word}.
    function automatic logic [ROW_W-1:0] preload_row(int r, logic [31:0] seed);
        logic [31:0] h;
        h = (32'(r) * 32'h9E3779B1) ^ seed;
        return {h[7:4] ^ h[31:28], h};
    endfunction

endpackage

// File: rtl/dpr_lane.sv
// One port's share of the storage. The stored value of a row is the XOR
// of both ports' banks, so each bank has a single writer and a single clock.
module dpr_lane
    import dpr_pkg::*;
#(
    parameter shape_e      SHAPE   = SHAPE_X36,
    parameter bit          PRIMARY = 1'b1,
    parameter logic [31:0] SEED    = 32'h0
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       din,
    input  logic [3:0]        pin,
    input  logic [ROW_W-1:0]  peer_word,
    input  logic [ROW_AW-1:0] peer_row,
    output logic [ROW_AW-1:0] my_row,
    output logic [ROW_W-1:0]  share_word,
    output logic [31:0]       rd_data,
    output logic [3:0]        rd_par
);

    localparam int DW       = shape_dw(SHAPE);
    localparam int PW       = shape_pw(SHAPE);
    localparam int SLICES   = ROW_DATA / DW;
    localparam int SEL_BITS = $clog2(SLICES);
    localparam logic [ROW_DATA-1:0] DKEEP = data_keep(SHAPE);
    localparam logic [ROW_PAR-1:0]  PKEEP = par_keep(SHAPE);

    logic [ROW_W-1:0] bank [ROWS];

    logic [4:0]       sel;
    logic [4:0]       doff;
    logic [1:0]       poff;
    logic [ROW_W-1:0] cur_word;
    logic [ROW_W-1:0] slot_mask;
    logic [ROW_W-1:0] placed;
    logic [ROW_W-1:0] merged;

    initial begin
        for (int r = 0; r < ROWS; r++) begin
            bank[r] = PRIMARY ? preload_row(r, SEED) : '0;
        end
    end

    // Low address bits pick the slice, the rest pick the row.
    assign my_row = ROW_AW'(addr >> SEL_BITS);
    assign sel    = 5'(addr & ADDR_W'(SLICES - 1));
    assign doff   = 5'(int'(sel) * DW);
    assign poff   = 2'(int'(sel) * PW);

    assign cur_word   = bank[my_row] ^ peer_word;
    assign share_word = bank[peer_row];

    always_comb begin
        slot_mask = {PKEEP << poff, DKEEP << doff};
        placed    = {(pin & PKEEP) << poff, (din & DKEEP) << doff};
        merged    = (cur_word & ~slot_mask) | (placed & slot_mask);
        rd_data   = (cur_word[ROW_DATA-1:0] >> doff) & DKEEP;
        rd_par    = (cur_word[ROW_W-1:ROW_DATA] >> poff) & PKEEP;
    end

    always_ff @(posedge clk) begin
        if (en && we) begin
            bank[my_row] <= merged ^ peer_word;
        end
    end

endmodule

// File: rtl/dpr_oreg.sv
// Port output register: power-up value, synchronous set/reset, hold on !en.
module dpr_oreg
    import dpr_pkg::*;
#(
    parameter shape_e           SHAPE    = SHAPE_X36,
    parameter logic [ROW_W-1:0] INIT_OUT = '0,
    parameter logic [ROW_W-1:0] SRVAL    = '0
) (
    input  logic        clk,
    input  logic        en,
    input  logic        sr,
    input  logic [31:0] rd_data,
    input  logic [3:0]  rd_par,
    output logic [31:0] dout,
    output logic [3:0]  pout
);

    localparam logic [ROW_W-1:0] KEEP = {par_keep(SHAPE), data_keep(SHAPE)};

    logic [ROW_W-1:0] q = INIT_OUT & KEEP;

    always_ff @(posedge clk) begin
        if (en) begin
            q <= sr ? (SRVAL & KEEP) : {rd_par, rd_data};
        end
    end

    assign dout = q[ROW_DATA-1:0];
    assign pout = q[ROW_W-1:ROW_DATA];

endmodule

// File: rtl/dpram_wconv.sv
module dpram_wconv
    import dpr_pkg::*;
#(
    parameter shape_e      SHAPE_A      = SHAPE_X9,
    parameter shape_e      SHAPE_B      = SHAPE_X1,
    parameter logic [35:0] INIT_OUT_A   = 36'h0,
    parameter logic [35:0] INIT_OUT_B   = 36'h0,
    parameter logic [35:0] SRVAL_A      = 36'h0,
    parameter logic [35:0] SRVAL_B      = 36'h0,
    parameter logic [31:0] PRELOAD_SEED = 32'h0
) (
    input  logic        clk_a,
    input  logic        en_a,
    input  logic        we_a,
    input  logic        sr_a,
    input  logic [13:0] addr_a,
    input  logic [31:0] din_a,
    input  logic [3:0]  pin_a,
    output logic [31:0] dout_a,
    output logic [3:0]  pout_a,
    input  logic        clk_b,
    input  logic        en_b,
    input  logic        we_b,
    input  logic        sr_b,
    input  logic [13:0] addr_b,
    input  logic [31:0] din_b,
    input  logic [3:0]  pin_b,
    output logic [31:0] dout_b,
    output logic [3:0]  pout_b
);

    localparam int NPORT = 2;

    logic              clk_v  [NPORT];
    logic              en_v   [NPORT];
    logic              we_v   [NPORT];
    logic              sr_v   [NPORT];
    logic [ADDR_W-1:0] addr_v [NPORT];
    logic [31:0]       din_v  [NPORT];
    logic [3:0]        pin_v  [NPORT];
    logic [31:0]       dout_v [NPORT];
    logic [3:0]        pout_v [NPORT];
    logic [ROW_AW-1:0] row_v  [NPORT];
    logic [ROW_W-1:0]  share_v[NPORT];

    assign clk_v[0]  = clk_a;   assign clk_v[1]  = clk_b;
    assign en_v[0]   = en_a;    assign en_v[1]   = en_b;
    assign we_v[0]   = we_a;    assign we_v[1]   = we_b;
    assign sr_v[0]   = sr_a;    assign sr_v[1]   = sr_b;
    assign addr_v[0] = addr_a;  assign addr_v[1] = addr_b;
    assign din_v[0]  = din_a;   assign din_v[1]  = din_b;
    assign pin_v[0]  = pin_a;   assign pin_v[1]  = pin_b;
    assign dout_a    = dout_v[0];
    assign pout_a    = pout_v[0];
    assign dout_b    = dout_v[1];
    assign pout_b    = pout_v[1];

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        localparam shape_e      SH   = (g == 0) ? SHAPE_A : SHAPE_B;
        localparam logic [35:0] IV   = (g == 0) ? INIT_OUT_A : INIT_OUT_B;
        localparam logic [35:0] SV   = (g == 0) ? SRVAL_A : SRVAL_B;
        localparam int          PEER = NPORT - 1 - g;

        logic [31:0] rd_data;
        logic [3:0]  rd_par;

        dpr_lane #(
            .SHAPE   (SH),
            .PRIMARY (g == 0),
            .SEED    (PRELOAD_SEED)
        ) u_lane (
            .clk        (clk_v[g]),
            .en         (en_v[g]),
            .we         (we_v[g]),
            .addr       (addr_v[g]),
            .din        (din_v[g]),
            .pin        (pin_v[g]),
            .peer_word  (share_v[PEER]),
            .peer_row   (row_v[PEER]),
            .my_row     (row_v[g]),
            .share_word (share_v[g]),
            .rd_data    (rd_data),
            .rd_par     (rd_par)
        );

        dpr_oreg #(
            .SHAPE    (SH),
            .INIT_OUT (IV),
            .SRVAL    (SV)
        ) u_oreg (
            .clk     (clk_v[g]),
            .en      (en_v[g]),
            .sr      (sr_v[g]),
            .rd_data (rd_data),
            .rd_par  (rd_par),
            .dout    (dout_v[g]),
            .pout    (pout_v[g])
        );
    end

endmodule

// File: rtl/dpram_wconv_chk.sv
module dpram_wconv_chk
    import dpr_pkg::*;
#(
    parameter shape_e      SHAPE_A = SHAPE_X9,
    parameter shape_e      SHAPE_B = SHAPE_X1,
    parameter logic [35:0] SRVAL_A = 36'h0,
    parameter logic [35:0] SRVAL_B = 36'h0
) (
    input logic        clk_a,
    input logic        en_a,
    input logic        sr_a,
    input logic [31:0] dout_a,
    input logic [3:0]  pout_a,
    input logic        clk_b,
    input logic        en_b,
    input logic        sr_b,
    input logic [31:0] dout_b,
    input logic [3:0]  pout_b
);

    localparam logic [35:0] KEEP_A = {par_keep(SHAPE_A), data_keep(SHAPE_A)};
    localparam logic [35:0] KEEP_B = {par_keep(SHAPE_B), data_keep(SHAPE_B)};

    logic primed_a = 1'b0;
    logic primed_b = 1'b0;

    always_ff @(posedge clk_a) primed_a <= 1'b1;
    always_ff @(posedge clk_b) primed_b <= 1'b1;

    // R5: set/reset loads the masked SRVAL
    a_r5_sr_value_a: assert property (@(posedge clk_a) disable iff (!primed_a)
        (en_a && sr_a) |=> ({pout_a, dout_a} == (SRVAL_A & KEEP_A)));
    a_r5_sr_value_b: assert property (@(posedge clk_b) disable iff (!primed_b)
        (en_b && sr_b) |=> ({pout_b, dout_b} == (SRVAL_B & KEEP_B)));

    // R6: disabled port holds its output
    a_r6_hold_a: assert property (@(posedge clk_a) disable iff (!primed_a)
        !en_a |=> $stable({pout_a, dout_a}));
    a_r6_hold_b: assert property (@(posedge clk_b) disable iff (!primed_b)
        !en_b |=> $stable({pout_b, dout_b}));

    // R8 (and R3 for narrow shapes): bits beyond the port's widths stay 0
    a_r8_unused_zero_a: assert property (@(posedge clk_a) disable iff (!primed_a)
        ({pout_a, dout_a} & ~KEEP_A) == 36'h0);
    a_r8_unused_zero_b: assert property (@(posedge clk_b) disable iff (!primed_b)
        ({pout_b, dout_b} & ~KEEP_B) == 36'h0);

endmodule

bind dpram_wconv dpram_wconv_chk #(
    .SHAPE_A (SHAPE_A),
    .SHAPE_B (SHAPE_B),
    .SRVAL_A (SRVAL_A),
    .SRVAL_B (SRVAL_B)
) u_chk (
    .clk_a  (clk_a),
    .en_a   (en_a),
    .sr_a   (sr_a),
    .dout_a (dout_a),
    .pout_a (pout_a),
    .clk_b  (clk_b),
    .en_b   (en_b),
    .sr_b   (sr_b),
    .dout_b (dout_b),
    .pout_b (pout_b)
);

// File: tb/test_dpram_wconv.sv
`timescale 1ns/1ps
module test_dpram_wconv;
    import dpr_pkg::*;

    localparam logic [31:0] SEED   = 32'hC0DE1234;
    localparam logic [35:0] INIT_A = 36'h3000012A5;
    localparam logic [35:0] INIT_B = 36'h000000000;
    localparam logic [35:0] SRV_A  = 36'hE0000FF5C;
    localparam logic [35:0] SRV_B  = 36'h000000001;
    localparam logic [35:0] KEEP_A = 36'h1000000FF;   // 8 data + 1 parity
    localparam logic [35:0] KEEP_B = 36'h000000001;   // 1 data, no parity

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic en_a = 0, we_a = 0, sr_a = 0, en_b = 0, we_b = 0, sr_b = 0;
    logic [13:0] addr_a = '0, addr_b = '0;
    logic [31:0] din_a = '0, din_b = '0;
    logic [3:0]  pin_a = '0, pin_b = '0;
    logic [31:0] dout_a, dout_b;
    logic [3:0]  pout_a, pout_b;

    always #4 clk_a = ~clk_a;                 // 125 MHz
    initial begin
        #3;
        forever #6 clk_b = ~clk_b;            // unrelated second clock
    end

    dpram_wconv #(
        .SHAPE_A(SHAPE_X9), .SHAPE_B(SHAPE_X1),
        .INIT_OUT_A(INIT_A), .INIT_OUT_B(INIT_B),
        .SRVAL_A(SRV_A), .SRVAL_B(SRV_B),
        .PRELOAD_SEED(SEED)
    ) i_dpram_wconv (
        .clk_a(clk_a), .en_a(en_a), .we_a(we_a), .sr_a(sr_a), .addr_a(addr_a),
        .din_a(din_a), .pin_a(pin_a), .dout_a(dout_a), .pout_a(pout_a),
        .clk_b(clk_b), .en_b(en_b), .we_b(we_b), .sr_b(sr_b), .addr_b(addr_b),
        .din_b(din_b), .pin_b(pin_b), .dout_b(dout_b), .pout_b(pout_b)
    );

    // Behavioural reference: flat bit spaces
    bit md [16384];
    bit mp [2048];
    logic [35:0] exp_a = INIT_A & KEEP_A;
    logic [35:0] exp_b = INIT_B & KEEP_B;
    string tag_a = "R7", tag_b = "R7";
    int checks = 0, bad = 0;
    bit done = 0;

    initial begin
        for (int r = 0; r < 512; r++) begin
            logic [31:0] h;
            h = (32'(r) * 32'h9E3779B1) ^ SEED;
            for (int i = 0; i < 32; i++) md[r*32+i] = h[i];
            for (int j = 0; j < 4; j++) mp[r*4+j] = h[4+j] ^ h[28+j];
        end
    end

    always @(negedge clk_a) if (!done) begin
        checks++;
        if ({pout_a, dout_a} !== exp_a) begin
            bad++;
            $display("FAIL %s port A: got %h expected %h", tag_a, {pout_a, dout_a}, exp_a);
        end
    end

    always @(negedge clk_b) if (!done) begin
        checks++;
        if ({pout_b, dout_b} !== exp_b) begin
            bad++;
            $display("FAIL %s port B: got %h expected %h", tag_b, {pout_b, dout_b}, exp_b);
        end
    end

    task automatic op_a(bit en, bit we, bit sr, int addr, logic [7:0] d, bit p, string tag);
        int a;
        a = addr % 2048;
        @(negedge clk_a);
        en_a = en; we_a = we; sr_a = sr; addr_a = 14'(addr);
        din_a = {24'hA5C3F0, d}; pin_a = {3'b111, p};
        @(posedge clk_a);
        if (en) begin
            if (sr) exp_a = SRV_A & KEEP_A;
            else begin
                exp_a = '0;
                for (int i = 0; i < 8; i++) exp_a[i] = md[a*8+i];
                exp_a[32] = mp[a];
            end
            if (we) begin
                for (int i = 0; i < 8; i++) md[a*8+i] = d[i];
                mp[a] = p;
            end
        end
        tag_a = tag;
        #1;
        en_a = 0; we_a = 0; sr_a = 0;
    endtask

    task automatic op_b(bit en, bit we, bit sr, int addr, bit d, string tag);
        int a;
        a = addr % 16384;
        @(negedge clk_b);
        en_b = en; we_b = we; sr_b = sr; addr_b = 14'(addr);
        din_b = {31'h5EADBEE1, d}; pin_b = 4'hF;
        @(posedge clk_b);
        if (en) begin
            exp_b = sr ? (SRV_B & KEEP_B) : {35'b0, md[a]};
            if (we) md[a] = d;
        end
        tag_b = tag;
        #1;
        en_b = 0; we_b = 0; sr_b = 0;
    endtask

    task automatic wrap_up();
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            wrap_up();
        end
    end

    initial begin
        // R7: power-up outputs (checked by monitors), then preload contents
        repeat (3) @(posedge clk_a);
        op_a(1, 0, 0, 0, 8'h00, 0, "R7");
        op_a(1, 0, 0, 2047, 8'h00, 0, "R7");
        op_b(1, 0, 0, 37, 0, "R7");
        op_b(1, 0, 0, 16383, 0, "R7");
        // R4: write returns old contents, then R1 readback
        op_a(1, 1, 0, 6, 8'h3C, 1, "R4");
        op_a(1, 0, 0, 6, 8'h00, 0, "R1");
        // R2: parallel to serial through the 1-bit port
        for (int i = 0; i < 8; i++) op_b(1, 0, 0, 48 + i, 0, "R2");
        // R3: narrow write flips a data bit, parity stays
        op_b(1, 1, 0, 48, 1, "R2");
        op_a(1, 0, 0, 6, 8'h00, 0, "R3");
        // R5: set/reset with a write in the same cycle
        op_a(1, 1, 1, 10, 8'h77, 0, "R5");
        op_a(1, 0, 0, 10, 8'h00, 0, "R5");
        op_b(1, 1, 1, 200, 0, "R5");
        op_b(1, 0, 0, 200, 0, "R5");
        // R6: disabled port neither writes nor changes output
        op_a(0, 1, 1, 10, 8'h11, 1, "R6");
        op_a(1, 0, 0, 10, 8'h00, 0, "R6");
        op_b(0, 1, 0, 200, 1, "R6");
        op_b(1, 0, 0, 200, 0, "R6");
        // R1: top address and ignored upper address bits
        op_a(1, 1, 0, 2047, 8'hC9, 0, "R1");
        op_a(1, 0, 0, 4095, 8'h00, 0, "R1");
        op_b(1, 0, 0, 16383, 0, "R2");
        // R8: junk on unused input bits never reaches outputs
        op_a(1, 1, 0, 300, 8'h81, 1, "R8");
        op_a(1, 0, 0, 300, 8'h00, 0, "R8");
        // R9: concurrent traffic on disjoint bits from both clocks
        fork
            for (int i = 0; i < 8; i++) op_a(1, 1, 0, 100 + i, 8'(8'h21 * i), i[0], "R9");
            for (int i = 0; i < 12; i++) op_b(1, i[0], 0, 16 + i, ~i[1], "R9");
        join
        for (int i = 0; i < 8; i++) op_a(1, 0, 0, 100 + i, 8'h00, 0, "R9");
        for (int i = 0; i < 12; i++) op_b(1, 0, 0, 16 + i, 0, "R9");
        repeat (3) @(posedge clk_b);
        wrap_up();
    end

endmodule